// File: doc/BRIEF.md
# Interrupt Moderation and Delay-Timer Controller

This block decides when a network controller's single interrupt line goes high. Event sources raise cause pulses, and each pulse may carry an "immediate" flag. The block merges the causes into a cause register and compares that register against a mask. It also enforces a minimum spacing between two assertions of the line. The spacing is a programmable throttle value multiplied by 256 ns, measured from the time of the last assertion. A free-running 32-bit nanosecond time base supplies the current time, and every comparison against it is safe across wrap-around.

The block also runs four delay timers. Two serve receive: a per-packet timer that restarts on each packet and an absolute timer that only starts. Two serve transmit in the same pairing. The timers count pulses of a prescaler tick input. When a timer expires it raises a summary cause. When an interrupt is actually posted, every running timer stops and its summary bit is set in the cause register. Software reads the cause register through a read strobe; the read clears the register and drops the line in the same cycle.

Top module: `intr_moderator`

## Requirements
- R1: After reset the line is low, the cause register and mask are zero, the throttle value is zero and all four delay timers are stopped.
- R2: Cause bits from an event are OR-ed into the cause register, and the register only gains bits until it is read. An event whose bits are all already set and whose immediate flag is low changes neither the line nor the cause register, and it leaves any armed deadline untouched.
- R3: An event that adds a new bit or carries the immediate flag triggers a posting attempt at once in three cases: the throttle value is zero, the immediate flag is set, or the current time is at least the last-assert time plus throttle×256 ns. A posting attempt at once cancels any armed deadline.
- R4: In every other case the event arms a deadline at the last-assert time plus throttle×256 ns, unless a deadline is already armed. Once the current time reaches the deadline, a posting attempt occurs.
- R5: If a posting attempt finds cause AND mask equal to zero, the line stays low and the cause bits are kept.
- R6: A successful post does four things. It stops any running receive timer and sets cause bit 7 (receive timer). It stops any running transmit timer and sets cause bit 0 (transmit done). It drives the line high. It records the current time as the last-assert time.
- R7: If a mask write leaves cause AND mask at zero, the line drops and any armed deadline is cancelled.
- R8: If a mask write leaves cause AND mask nonzero, the block posts at once when the throttle value is zero. Otherwise it arms a deadline at the current time plus throttle×256 ns, if none is armed.
- R9: Each received packet has three possible effects. It restarts the receive packet timer when that delay is nonzero. It starts the receive absolute timer when that delay is nonzero and the timer is stopped. When both receive delays are zero, it raises cause bit 7 directly.
- R10: A transmit delayed-interrupt request restarts the transmit packet timer when its delay is nonzero. It starts the transmit absolute timer only when both transmit delays are nonzero and that timer is stopped.
- R11: A timer loaded with N expires on the Nth tick pulse after the load. A receive timer expiry raises cause bit 7 and a transmit timer expiry raises cause bit 0, as ordinary non-immediate events. The delay register select codes are 0 for receive packet, 1 for receive absolute, 2 for transmit packet and 3 for transmit absolute.
- R12: A read strobe presents the cause value that is current during that cycle. After the clock edge the cause register is zero and the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 32 | Free-running time base in ns |
| dlyTick | input | 1 | Prescaler tick for the delay timers |
| causeValid | input | 1 | Cause event strobe |
| causeNow | input | 1 | Immediate flag of the cause event |
| causeBits | input | 8 | Cause bits of the event |
| rxPktDone | input | 1 | One received packet has been stored |
| txDelayedDone | input | 1 | Transmit descriptor requested a delayed interrupt |
| wrMaskValid | input | 1 | Mask write strobe |
| wrMaskData | input | 8 | New mask value |
| wrThrValid | input | 1 | Throttle write strobe |
| wrThrData | input | 16 | New throttle value, in units of 256 ns |
| wrDlyValid | input | 1 | Delay register write strobe |
| wrDlySel | input | 2 | Delay register select (0 rx packet, 1 rx absolute, 2 tx packet, 3 tx absolute) |
| wrDlyData | input | 16 | New delay, in tick pulses |
| causeRead | input | 1 | Read-and-clear strobe for the cause register |
| intrLine | output | 1 | Interrupt line |
| causeValue | output | 8 | Current cause register |

## Verification
All state is registered, so every result of a strobe appears one cycle after the edge that samples it. The bench changes inputs at the falling edge and compares at the following falling edge. A throttle deadline is checked by noting the time value that each rising edge samples. The line has to rise at the edge whose sampled time equals the computed deadline, and at no edge before it. Timer expiries are checked right after the Nth tick pulse, with a check after tick N-1 that the line is still low.

// File: rtl/intr_mod_pkg.sv
package intr_mod_pkg;

  typedef enum logic [1:0] {
    DLY_RX_PKT = 2'd0,
    DLY_RX_ABS = 2'd1,
    DLY_TX_PKT = 2'd2,
    DLY_TX_ABS = 2'd3
  } dlySel_e;

  // datapath observations handed to the control
  typedef struct packed {
    logic postTry;
    logic immediate;
    logic thrZero;
    logic elapsed;
    logic dlExpired;
    logic armed;
    logic maskedAny;
    logic maskWrite;
  } status_t;

  // control strobes handed back to the datapath
  typedef struct packed {
    logic assertLine;
    logic deassertLine;
    logic armFromLast;
    logic armFromNow;
    logic disarm;
  } strobe_t;

endpackage

// File: rtl/intr_dly_timer.sv
module intr_dly_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         stop,
  output logic         running,
  output logic         expire
);
  logic [W-1:0] cntQ;

  assign running = (cntQ != '0);
  assign expire  = tick && (cntQ == W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (load)            cntQ <= loadVal;
    else if (stop)            cntQ <= '0;
    else if (tick && running) cntQ <= cntQ - W'(1);
  end
endmodule

// File: rtl/intr_mod_ctrl.sv
module intr_mod_ctrl
  import intr_mod_pkg::*;
(
  input  status_t st,
  output strobe_t stb
);
  logic postNow, postArm, maskPath, maskPost, maskArm, dlPost, attempt;

  always_comb begin
    postNow  = st.postTry && (st.thrZero || st.immediate || st.elapsed);
    postArm  = st.postTry && !postNow;
    maskPath = !st.postTry && st.maskWrite;
    maskPost = maskPath && st.maskedAny && st.thrZero;
    maskArm  = maskPath && st.maskedAny && !st.thrZero;
    dlPost   = !st.postTry && !st.maskWrite && st.armed && st.dlExpired;
    attempt  = postNow || maskPost || dlPost;

    stb.assertLine   = attempt && st.maskedAny;
    stb.deassertLine = maskPath && !st.maskedAny;
    stb.disarm       = postNow || dlPost || stb.deassertLine || stb.assertLine;
    stb.armFromLast  = postArm && !st.armed;
    stb.armFromNow   = maskArm && !st.armed;
  end
endmodule

// File: rtl/intr_mod_dp.sv
module intr_mod_dp
  import intr_mod_pkg::*;
#(
  parameter int TIME_W    = 32,
  parameter int CAUSE_W   = 8,
  parameter int THR_W     = 16,
  parameter int DLY_W     = 16,
  parameter int THR_SHIFT = 8,
  parameter int RX_BIT    = 7,
  parameter int TX_BIT    = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIME_W-1:0]  timeNow,
  input  logic               dlyTick,
  input  logic               causeValid,
  input  logic               causeNow,
  input  logic [CAUSE_W-1:0] causeBits,
  input  logic               rxPktDone,
  input  logic               txDelayedDone,
  input  logic               wrMaskValid,
  input  logic [CAUSE_W-1:0] wrMaskData,
  input  logic               wrThrValid,
  input  logic [THR_W-1:0]   wrThrData,
  input  logic               wrDlyValid,
  input  logic [1:0]         wrDlySel,
  input  logic [DLY_W-1:0]   wrDlyData,
  input  logic               causeRead,
  input  strobe_t            stb,
  output status_t            st,
  output logic               intrLine,
  output logic [CAUSE_W-1:0] causeValue,
  output logic [CAUSE_W-1:0] maskQ,
  output logic               deadlineArmed
);
  localparam int NTMR = 4;

  logic [CAUSE_W-1:0] causeQ, causeIn, causeBase, maskNext, foldBits;
  logic [THR_W-1:0]   thrQ;
  logic [TIME_W-1:0]  lastQ, dlQ, spacing, sinceLast, toDeadline;
  logic               armedQ, lineQ;
  logic [DLY_W-1:0]   dlyQ [NTMR];
  logic [NTMR-1:0]    tLoad, tRun, tExp;
  logic               rxHit, txHit, rxDirect;

  // delay registers and timers
  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (!rstN) dlyQ[i] <= '0;
      else if (wrDlyValid && wrDlySel == 2'(i)) dlyQ[i] <= wrDlyData;
    end
    intr_dly_timer #(.W(DLY_W)) i_tmr (
      .clk(clk), .rstN(rstN), .tick(dlyTick), .load(tLoad[i]),
      .loadVal(dlyQ[i]), .stop(stb.assertLine),
      .running(tRun[i]), .expire(tExp[i])
    );
  end

  always_comb begin
    tLoad[0] = rxPktDone && (dlyQ[0] != '0);
    tLoad[1] = rxPktDone && (dlyQ[1] != '0) && !tRun[1];
    tLoad[2] = txDelayedDone && (dlyQ[2] != '0);
    tLoad[3] = txDelayedDone && (dlyQ[2] != '0) && (dlyQ[3] != '0) && !tRun[3];
    rxDirect = rxPktDone && (dlyQ[0] == '0) && (dlyQ[1] == '0);
    rxHit    = tExp[0] || tExp[1] || rxDirect;
    txHit    = tExp[2] || tExp[3];

    causeIn = causeValid ? causeBits : '0;
    if (rxHit) causeIn[RX_BIT] = 1'b1;
    if (txHit) causeIn[TX_BIT] = 1'b1;

    foldBits = '0;
    if (stb.assertLine && (tRun[0] || tRun[1])) foldBits[RX_BIT] = 1'b1;
    if (stb.assertLine && (tRun[2] || tRun[3])) foldBits[TX_BIT] = 1'b1;

    causeBase  = causeRead ? '0 : causeQ;
    maskNext   = wrMaskValid ? wrMaskData : maskQ;
    spacing    = {{(TIME_W-THR_W){1'b0}}, thrQ} << THR_SHIFT;
    sinceLast  = timeNow - lastQ;
    toDeadline = timeNow - dlQ;

    st.postTry   = (causeIn != '0) &&
                   (((causeIn & ~causeQ) != '0) || (causeValid && causeNow));
    st.immediate = causeValid && causeNow;
    st.thrZero   = (thrQ == '0);
    st.elapsed   = (sinceLast >= spacing);
    st.dlExpired = !toDeadline[TIME_W-1];
    st.armed     = armedQ;
    st.maskedAny = (((causeBase | causeIn) & maskNext) != '0);
    st.maskWrite = wrMaskValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
      thrQ   <= '0;
      lastQ  <= '0;
      dlQ    <= '0;
      armedQ <= 1'b0;
      lineQ  <= 1'b0;
    end else begin
      causeQ <= causeBase | causeIn | foldBits;
      maskQ  <= maskNext;
      if (wrThrValid) thrQ <= wrThrData;
      if (stb.assertLine) lastQ <= timeNow;
      if (stb.assertLine)                         lineQ <= 1'b1;
      else if (causeRead || stb.deassertLine)     lineQ <= 1'b0;
      if (stb.disarm) armedQ <= 1'b0;
      else if (stb.armFromLast) begin
        armedQ <= 1'b1;
        dlQ    <= lastQ + spacing;
      end else if (stb.armFromNow) begin
        armedQ <= 1'b1;
        dlQ    <= timeNow + spacing;
      end
    end
  end

  assign intrLine      = lineQ;
  assign causeValue    = causeQ;
  assign deadlineArmed = armedQ;
endmodule

// File: rtl/intr_moderator.sv
module intr_moderator
  import intr_mod_pkg::*;
#(
  parameter int TIME_W  = 32,
  parameter int CAUSE_W = 8,
  parameter int THR_W   = 16,
  parameter int DLY_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIME_W-1:0]  timeNow,
  input  logic               dlyTick,
  input  logic               causeValid,
  input  logic               causeNow,
  input  logic [CAUSE_W-1:0] causeBits,
  input  logic               rxPktDone,
  input  logic               txDelayedDone,
  input  logic               wrMaskValid,
  input  logic [CAUSE_W-1:0] wrMaskData,
  input  logic               wrThrValid,
  input  logic [THR_W-1:0]   wrThrData,
  input  logic               wrDlyValid,
  input  logic [1:0]         wrDlySel,
  input  logic [DLY_W-1:0]   wrDlyData,
  input  logic               causeRead,
  output logic               intrLine,
  output logic [CAUSE_W-1:0] causeValue
);
  status_t            st;
  strobe_t            stb;
  logic [CAUSE_W-1:0] maskQ;
  logic               deadlineArmed;

  intr_mod_dp #(
    .TIME_W(TIME_W), .CAUSE_W(CAUSE_W), .THR_W(THR_W), .DLY_W(DLY_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .dlyTick(dlyTick),
    .causeValid(causeValid), .causeNow(causeNow), .causeBits(causeBits),
    .rxPktDone(rxPktDone), .txDelayedDone(txDelayedDone),
    .wrMaskValid(wrMaskValid), .wrMaskData(wrMaskData),
    .wrThrValid(wrThrValid), .wrThrData(wrThrData),
    .wrDlyValid(wrDlyValid), .wrDlySel(wrDlySel), .wrDlyData(wrDlyData),
    .causeRead(causeRead), .stb(stb), .st(st),
    .intrLine(intrLine), .causeValue(causeValue),
    .maskQ(maskQ), .deadlineArmed(deadlineArmed)
  );

  intr_mod_ctrl i_ctrl (.st(st), .stb(stb));
endmodule

// File: rtl/intr_mod_chk.sv
module intr_mod_chk #(
  parameter int CAUSE_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               dlyTick,
  input logic               causeValid,
  input logic               causeNow,
  input logic [CAUSE_W-1:0] causeBits,
  input logic               rxPktDone,
  input logic               txDelayedDone,
  input logic               wrMaskValid,
  input logic [CAUSE_W-1:0] wrMaskData,
  input logic               causeRead,
  input logic               intrLine,
  input logic [CAUSE_W-1:0] causeValue,
  input logic [CAUSE_W-1:0] maskQ,
  input logic               deadlineArmed
);
  // R5: a high line always has an unmasked cause behind it
  p_line_has_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    intrLine |-> ((causeValue & maskQ) != '0));

  // R2: without a read the cause register only gains bits
  p_cause_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    !causeRead |=> ((causeValue & $past(causeValue)) == $past(causeValue)));

  // R2: a repeated non-immediate cause leaves everything as it was
  p_dup_no_effect_r2: assert property (@(posedge clk) disable iff (!rstN)
    (causeValid && !causeNow && ((causeBits & ~causeValue) == '0) &&
     !causeRead && !wrMaskValid && !dlyTick && !rxPktDone &&
     !txDelayedDone && !deadlineArmed)
    |=> ($stable(intrLine) && $stable(causeValue)));

  // R7: a mask write that hides every cause drops the line
  p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrMaskValid && !causeValid && !rxPktDone && !dlyTick &&
     ((causeValue & wrMaskData) == '0)) |=> !intrLine);

  // R12: a lone read clears the register and the line
  p_read_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    (causeRead && !causeValid && !rxPktDone && !dlyTick)
    |=> (causeValue == '0 && !intrLine));

  // R3: the line only rises after an event, a mask write, a tick or an armed deadline
  p_rise_has_reason_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intrLine) |->
      $past(causeValid || wrMaskValid || dlyTick || rxPktDone || deadlineArmed));
endmodule

bind intr_moderator intr_mod_chk #(.CAUSE_W(CAUSE_W)) i_intr_mod_chk (
  .clk(clk), .rstN(rstN), .dlyTick(dlyTick), .causeValid(causeValid),
  .causeNow(causeNow), .causeBits(causeBits), .rxPktDone(rxPktDone),
  .txDelayedDone(txDelayedDone), .wrMaskValid(wrMaskValid),
  .wrMaskData(wrMaskData), .causeRead(causeRead), .intrLine(intrLine),
  .causeValue(causeValue), .maskQ(maskQ), .deadlineArmed(deadlineArmed)
);

// File: tb/test_intr_moderator.sv
module test_intr_moderator;
  import intr_mod_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timeNow = '0;
  logic        dlyTick = 0, causeValid = 0, causeNow = 0, rxPktDone = 0, txDelayedDone = 0;
  logic [7:0]  causeBits = '0, wrMaskData = '0;
  logic        wrMaskValid = 0, wrThrValid = 0, wrDlyValid = 0, causeRead = 0;
  logic [15:0] wrThrData = '0, wrDlyData = '0;
  logic [1:0]  wrDlySel = '0;
  logic        intrLine;
  logic [7:0]  causeValue;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) timeNow <= timeNow + 32'd8;

  intr_moderator i_intr_moderator (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .dlyTick(dlyTick),
    .causeValid(causeValid), .causeNow(causeNow), .causeBits(causeBits),
    .rxPktDone(rxPktDone), .txDelayedDone(txDelayedDone),
    .wrMaskValid(wrMaskValid), .wrMaskData(wrMaskData),
    .wrThrValid(wrThrValid), .wrThrData(wrThrData),
    .wrDlyValid(wrDlyValid), .wrDlySel(wrDlySel), .wrDlyData(wrDlyData),
    .causeRead(causeRead), .intrLine(intrLine), .causeValue(causeValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clrIn;
    dlyTick = 0; causeValid = 0; causeNow = 0; causeBits = '0;
    rxPktDone = 0; txDelayedDone = 0; wrMaskValid = 0; wrThrValid = 0;
    wrDlyValid = 0; causeRead = 0;
  endtask

  // every task drives right after a falling edge and returns after the next one
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic sendCause(input logic [7:0] b, input logic imm);
    causeValid = 1; causeBits = b; causeNow = imm; @(negedge clk); clrIn();
  endtask
  task automatic wrMask(input logic [7:0] m);
    wrMaskValid = 1; wrMaskData = m; @(negedge clk); clrIn();
  endtask
  task automatic wrThr(input logic [15:0] t);
    wrThrValid = 1; wrThrData = t; @(negedge clk); clrIn();
  endtask
  task automatic wrDly(input dlySel_e s, input logic [15:0] v);
    wrDlyValid = 1; wrDlySel = s; wrDlyData = v; @(negedge clk); clrIn();
  endtask
  task automatic rxEv;
    rxPktDone = 1; @(negedge clk); clrIn();
  endtask
  task automatic txEv;
    txDelayedDone = 1; @(negedge clk); clrIn();
  endtask
  task automatic ticks(input int n);
    repeat (n) begin dlyTick = 1; @(negedge clk); clrIn(); end
  endtask
  task automatic readCause(input string req, input logic [7:0] exp);
    chk(req, causeValue, exp);
    causeRead = 1; @(negedge clk); clrIn();
  endtask
  // time sampled by the edge at which the line first rises
  task automatic waitRise(input string req, input logic [31:0] expT);
    logic [31:0] tS;
    bit seen;
    seen = 0; tS = '0;
    for (int i = 0; i < 400 && !seen; i++) begin
      tS = timeNow;
      @(negedge clk);
      if (intrLine) seen = 1;
    end
    chk(req, seen ? tS : 32'hffff_ffff, expT);
  endtask

  function automatic logic modelHit(input logic [7:0] c, input logic [7:0] m);
    return (c & m) != 8'h00;
  endfunction

  logic [31:0] tA, tD, tM;
  logic [7:0]  mCause, mMask, rb;
  logic        mLine, rImm;
  int          op;

  initial begin
    clrIn();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 line", {31'b0, intrLine}, 32'd0);
    chk("R1 cause", {24'b0, causeValue}, 32'd0);

    // R1 zero throttle after reset, R3 post at once
    wrMask(8'h02);
    tA = timeNow;
    sendCause(8'h02, 1'b0);
    chk("R3 zero throttle line", {31'b0, intrLine}, 32'd1);
    readCause("R12 read value", 8'h02);
    chk("R12 line after read", {31'b0, intrLine}, 32'd0);
    chk("R12 cause after read", {24'b0, causeValue}, 32'd0);

    // R4 throttle from last assertion, 2*256 ns
    wrThr(16'd2);
    sendCause(8'h02, 1'b0);
    chk("R4 held back", {31'b0, intrLine}, 32'd0);
    sendCause(8'h02, 1'b0);
    chk("R2 duplicate line", {31'b0, intrLine}, 32'd0);
    chk("R2 duplicate cause", {24'b0, causeValue}, 32'h02);
    waitRise("R4 deadline from last assert", tA + 32'd512);
    tD = tA + 32'd512;
    readCause("R12 read after deadline", 8'h02);

    // R3 immediate overrides throttle and cancels the deadline
    sendCause(8'h02, 1'b0);
    chk("R4 armed again", {31'b0, intrLine}, 32'd0);
    sendCause(8'h02, 1'b1);
    chk("R3 immediate", {31'b0, intrLine}, 32'd1);
    readCause("R3 read", 8'h02);
    idle(90);
    chk("R3 deadline cancelled", {31'b0, intrLine}, 32'd0);

    // R5, R8, R7 with zero throttle
    wrMask(8'h00);
    wrThr(16'd0);
    sendCause(8'h08, 1'b0);
    chk("R5 masked line", {31'b0, intrLine}, 32'd0);
    chk("R5 masked cause", {24'b0, causeValue}, 32'h08);
    wrMask(8'h08);
    chk("R8 mask write posts", {31'b0, intrLine}, 32'd1);
    wrMask(8'h00);
    chk("R7 mask hides line", {31'b0, intrLine}, 32'd0);
    chk("R7 cause kept", {24'b0, causeValue}, 32'h08);
    readCause("R7 read", 8'h08);

    // R8 mask write with throttle arms from now
    wrThr(16'd2);
    idle(70);
    sendCause(8'h08, 1'b0);
    chk("R5 masked after spacing", {31'b0, intrLine}, 32'd0);
    tM = timeNow;
    wrMask(8'h08);
    chk("R8 held by throttle", {31'b0, intrLine}, 32'd0);
    waitRise("R8 deadline from mask write", tM + 32'd512);
    readCause("R8 read", 8'h08);

    // delay timers, throttle off
    wrThr(16'd0);
    wrMask(8'h81);
    wrDly(DLY_RX_PKT, 16'd3);
    rxEv();
    ticks(2);
    chk("R11 before expiry", {31'b0, intrLine}, 32'd0);
    ticks(1);
    chk("R11 rx packet expiry", {31'b0, intrLine}, 32'd1);
    readCause("R11 rx cause", 8'h80);

    wrDly(DLY_RX_PKT, 16'd0);
    rxEv();
    chk("R9 direct rx post", {31'b0, intrLine}, 32'd1);
    readCause("R9 direct cause", 8'h80);

    wrDly(DLY_RX_PKT, 16'd5);
    rxEv();
    sendCause(8'h01, 1'b0);
    chk("R6 post line", {31'b0, intrLine}, 32'd1);
    readCause("R6 rx fold", 8'h81);
    ticks(6);
    chk("R6 rx timer stopped", {24'b0, causeValue}, 32'h00);

    wrDly(DLY_RX_PKT, 16'd10);
    wrDly(DLY_RX_ABS, 16'd4);
    rxEv();
    ticks(2);
    rxEv();
    ticks(1);
    chk("R9 absolute not restarted", {31'b0, intrLine}, 32'd0);
    ticks(1);
    chk("R9 absolute expiry", {31'b0, intrLine}, 32'd1);
    readCause("R9 absolute cause", 8'h80);

    wrDly(DLY_TX_PKT, 16'd2);
    txEv();
    ticks(1);
    chk("R10 tx before expiry", {31'b0, intrLine}, 32'd0);
    ticks(1);
    chk("R10 tx packet expiry", {31'b0, intrLine}, 32'd1);
    readCause("R10 tx cause", 8'h01);

    wrDly(DLY_TX_PKT, 16'd0);
    wrDly(DLY_TX_ABS, 16'd3);
    txEv();
    ticks(5);
    chk("R10 absolute needs both", {24'b0, causeValue}, 32'h00);

    wrDly(DLY_TX_PKT, 16'd6);
    txEv();
    ticks(3);
    chk("R10 tx absolute expiry", {31'b0, intrLine}, 32'd1);
    readCause("R10 tx absolute cause", 8'h01);

    // random phase, throttle zero, no timers running
    rb = $urandom(32'd20240611);
    mCause = 8'h00; mMask = 8'h00; mLine = 0;
    wrMask(8'h00);
    for (int n = 0; n < 300; n++) begin
      op = $urandom_range(0, 3);
      if (op == 0) begin
        rb = 8'($urandom); rImm = 1'($urandom);
        sendCause(rb, rImm);
        if (rb != 8'h00 && (((rb & ~mCause) != 8'h00) || rImm)) begin
          mCause = mCause | rb;
          if (modelHit(mCause, mMask)) mLine = 1;
        end
        chk("R2 random cause", {24'b0, causeValue}, {24'b0, mCause});
      end else if (op == 1) begin
        rb = 8'($urandom);
        wrMask(rb);
        mMask = rb;
        mLine = modelHit(mCause, mMask);
      end else if (op == 2) begin
        readCause("R12 random read", mCause);
        mCause = 8'h00; mLine = 0;
      end else begin
        idle(1);
      end
      chk("R8 random line", {31'b0, intrLine}, {31'b0, mLine});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule